// File: doc/BRIEF.md
# Write-Only Port Shadow Readback Unit

This block watches every processor I/O write and keeps a private byte copy of the legacy configuration ports that cannot be read back. These are the DMA channel address and count registers, the DMA command, mode and mask registers, the interrupt controller initialization and operation words, the RTC index/NMI port, the serial FIFO control ports and the timer 0 count. Power management or save/restore code can then recover what was programmed without touching the peripherals.

Several of these registers share one I/O address. 16-bit registers arrive as two bytes on one port. Mode writes for all channels of a DMA controller use a single port. The interrupt controller's initialization words arrive in sequence on the same odd port. The unit rebuilds per-register state from these shared ports, so every register gets its own slot in a 58-entry table (slots 00h to 39h).

Software reads a slot in two steps. It writes the slot number to the unit's own shadow port (`sh_wr`, with the number on `io_wdata`). It then reads that port (`sh_rd`). The read data appears on `sh_rdata` after the clock edge that samples the read strobe.

Top module: `wo_shadow_unit`

## Requirements
- R1: An `sh_wr` cycle stores `io_wdata` as the selected slot. An `sh_rd` cycle loads `sh_rdata` with that slot's content at the next edge. `sh_rdata` holds its value in every cycle without `sh_rd`.
- R2: Reset clears all slots, the selected slot, `sh_rdata` and every byte pointer to zero, and returns both interrupt sequencers to idle.
- R3: Each DMA controller has a byte pointer. It starts low and toggles on every write to any channel address or count port of that controller, including channel 4 ports C0h/C2h, which are not stored. A low write goes to the even slot and a high write to the odd slot. The slot map is as follows. For first-controller channel n, address port 2n goes to slots 4n/4n+1 and count port 2n+1 goes to slots 4n+2/4n+3. On the second controller, address ports C4h/C8h/CCh go to 16h/1Ah/1Eh and count ports C6h/CAh/CEh go to 18h/1Ch/20h, with the high byte in the next slot.
- R4: A write to 0Ch clears the first controller's pointer, and a write to D8h clears the second's.
- R5: Command and mask writes are stored whole: 08h to 10h, 0Fh to 15h, D0h to 22h and DEh to 26h.
- R6: A write to 0Bh with data bits 1:0 = n is stored in slot 11h+n. A write to D6h with bits 1:0 = 1, 2 or 3 is stored in 23h, 24h or 25h. With bits 1:0 = 0 it changes no slot.
- R7: On the even PIC port (20h/A0h), a write with bit 4 set is ICW1 (slot 27h/2Ch) and restarts the sequence. The following odd-port (21h/A1h) writes are stored in order: ICW2 (28h/2Dh), then ICW3 (29h/2Eh) only if ICW1 bit 1 was 0, then ICW4 (2Ah/2Fh) only if ICW1 bit 0 was 1. Later odd-port writes change no slot.
- R8: An even-port PIC write with bit 4 clear and bit 3 set is stored in 38h/39h, keeping only bits 0, 2 and 5 (others read 0). With bit 3 clear it is stored whole in 2Bh/30h.
- R9: Port 70h goes to slot 31h. Port 40h goes to 36h (low) and 37h (high) under its own pointer, which toggles on each such write and starts low.
- R10: Ports 3FAh, 2FAh, 3EAh and 2EAh go to slots 32h–35h, keeping only bits 0, 3, 6 and 7.
- R11: The full 16-bit address is decoded. An 8-bit port is matched only when address bits 15:8 are zero. A non-matching write changes no slot and no pointer.
- R12: A selected slot above 39h reads 00h. The selection is kept until the next `sh_wr`.
- R13: When a snooped write and `sh_rd` fall in the same cycle on the selected slot, the read returns the value held before that write. The next read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the current write |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_wdata | input | 8 | Write data for I/O writes and for the shadow port |
| sh_wr | input | 1 | Shadow port write: select slot from `io_wdata` |
| sh_rd | input | 1 | Shadow port read: load `sh_rdata` |
| sh_rdata | output | 8 | Read data of the shadow port |

## Verification
A snooped peripheral write and a shadow-port read can land in the same cycle and target the same slot. This collision decides whether the returned byte is the old or the new content. The bench selects the RTC slot, writes a known value to port 70h, and then asserts `io_wr` to 70h with a new value together with `sh_rd`. The read must return the earlier value, and a following read must return the new one. The pointer-sensitive paths are also interleaved so that a clear-pointer write falls between the two halves of a 16-bit register.

// File: rtl/shrb_pkg.sv
package shrb_pkg;

   localparam int SLOT_W  = 6;   // slot field width
   localparam int IDX_W   = 8;   // selection register width (full byte)
   localparam int NUM_ENT = 58;  // slots 00h..39h

   localparam logic [7:0] FIFO_KEEP = 8'hC9;  // bits 0,3,6,7
   localparam logic [7:0] OCW3_KEEP = 8'h25;  // bits 0,2,5

   // one shadow update request from a decoder
   typedef struct packed {
      logic              vld;
      logic [SLOT_W-1:0] slot;
      logic [7:0]        data;
   } shw_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ICW2 = 2'd1,
      PH_ICW3 = 2'd2,
      PH_ICW4 = 2'd3
   } pic_phase_t;

endpackage

// File: rtl/shrb_dma_snoop.sv
module shrb_dma_snoop
   import shrb_pkg::*;
#(
   parameter int         NCH        = 4,
   parameter int         FIRST_CH   = 0,
   parameter logic [7:0] REG_BASE   = 8'h00,
   parameter int         REG_STEP   = 1,
   parameter logic [7:0] CMD_PORT   = 8'h08,
   parameter logic [7:0] MODE_PORT  = 8'h0B,
   parameter logic [7:0] MASK_PORT  = 8'h0F,
   parameter logic [7:0] CLR_PORT   = 8'h0C,
   parameter int         REG_SLOT0  = 'h00,
   parameter int         CMD_SLOT   = 'h10,
   parameter int         MODE_SLOT0 = 'h11,
   parameter int         MASK_SLOT  = 'h15
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] io_addr,
   input  logic        io_wr,
   input  logic [7:0]  io_wdata,
   output shw_t        req,
   output logic        ptr_o
);

   localparam int NREG = 2 * NCH;

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("shrb_dma_snoop: NCH must be 1..4");
   end
   if (FIRST_CH < 0 || FIRST_CH >= NCH) begin : g_bad_first
      $error("shrb_dma_snoop: FIRST_CH out of range");
   end
   if (REG_STEP != 1 && REG_STEP != 2) begin : g_bad_step
      $error("shrb_dma_snoop: REG_STEP must be 1 or 2");
   end

   logic            wr8;
   logic [NREG-1:0] reg_hit;
   logic            clr_hit, cmd_hit, mode_hit, mask_hit;
   logic            ptr_q;

   assign wr8 = io_wr && (io_addr[15:8] == 8'h00);

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      localparam logic [7:0] PORT = 8'(REG_BASE + k * REG_STEP);
      assign reg_hit[k] = wr8 && (io_addr[7:0] == PORT);
   end

   assign clr_hit  = wr8 && (io_addr[7:0] == CLR_PORT);
   assign cmd_hit  = wr8 && (io_addr[7:0] == CMD_PORT);
   assign mode_hit = wr8 && (io_addr[7:0] == MODE_PORT);
   assign mask_hit = wr8 && (io_addr[7:0] == MASK_PORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr_q <= 1'b0;
      else if (clr_hit)    ptr_q <= 1'b0;
      else if (|reg_hit)   ptr_q <= ~ptr_q;
   end

   assign ptr_o = ptr_q;

   always_comb begin
      int sel;
      req      = '0;
      req.data = io_wdata;
      sel      = int'(io_wdata[1:0]);
      for (int k = 0; k < NREG; k++) begin
         if (reg_hit[k] && (k / 2) >= FIRST_CH) begin
            req.vld  = 1'b1;
            req.slot = SLOT_W'(REG_SLOT0 + (k / 2 - FIRST_CH) * 4
                               + (k % 2) * 2 + int'(ptr_q));
         end
      end
      if (cmd_hit) begin
         req.vld  = 1'b1;
         req.slot = SLOT_W'(CMD_SLOT);
      end
      if (mask_hit) begin
         req.vld  = 1'b1;
         req.slot = SLOT_W'(MASK_SLOT);
      end
      if (mode_hit && sel >= FIRST_CH && sel < NCH) begin
         req.vld  = 1'b1;
         req.slot = SLOT_W'(MODE_SLOT0 + sel - FIRST_CH);
      end
   end

endmodule

// File: rtl/shrb_pic_snoop.sv
module shrb_pic_snoop
   import shrb_pkg::*;
#(
   parameter logic [7:0] EVEN_PORT = 8'h20,
   parameter int         ICW1_SLOT = 'h27,
   parameter int         OCW2_SLOT = 'h2B,
   parameter int         OCW3_SLOT = 'h38
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] io_addr,
   input  logic        io_wr,
   input  logic [7:0]  io_wdata,
   output shw_t        req
);

   if (EVEN_PORT[0] != 1'b0) begin : g_bad_port
      $error("shrb_pic_snoop: EVEN_PORT must be even");
   end

   localparam logic [7:0] ODD_PORT = EVEN_PORT | 8'h01;

   logic       wr8, ev_hit, od_hit, icw1_hit;
   pic_phase_t ph_q, ph_d;
   logic       want3_q, want4_q;

   assign wr8      = io_wr && (io_addr[15:8] == 8'h00);
   assign ev_hit   = wr8 && (io_addr[7:0] == EVEN_PORT);
   assign od_hit   = wr8 && (io_addr[7:0] == ODD_PORT);
   assign icw1_hit = ev_hit && io_wdata[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         want3_q <= 1'b0;
         want4_q <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (icw1_hit) begin
            want3_q <= ~io_wdata[1];
            want4_q <= io_wdata[0];
         end
      end
   end

   always_comb begin
      ph_d     = ph_q;
      req      = '0;
      req.data = io_wdata;
      if (ev_hit) begin
         req.vld = 1'b1;
         if (io_wdata[4]) begin
            req.slot = SLOT_W'(ICW1_SLOT);
            ph_d     = PH_ICW2;
         end else if (io_wdata[3]) begin
            req.slot = SLOT_W'(OCW3_SLOT);
            req.data = io_wdata & OCW3_KEEP;
         end else begin
            req.slot = SLOT_W'(OCW2_SLOT);
         end
      end else if (od_hit) begin
         unique case (ph_q)
            PH_ICW2: begin
               req.vld  = 1'b1;
               req.slot = SLOT_W'(ICW1_SLOT + 1);
               ph_d     = want3_q ? PH_ICW3 : (want4_q ? PH_ICW4 : PH_IDLE);
            end
            PH_ICW3: begin
               req.vld  = 1'b1;
               req.slot = SLOT_W'(ICW1_SLOT + 2);
               ph_d     = want4_q ? PH_ICW4 : PH_IDLE;
            end
            PH_ICW4: begin
               req.vld  = 1'b1;
               req.slot = SLOT_W'(ICW1_SLOT + 3);
               ph_d     = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/shrb_misc_snoop.sv
module shrb_misc_snoop
   import shrb_pkg::*;
#(
   parameter int                     NFIFO      = 4,
   parameter logic [NFIFO-1:0][15:0] FIFO_PORT  = {16'h02EA, 16'h03EA, 16'h02FA, 16'h03FA},
   parameter int                     FIFO_SLOT0 = 'h32,
   parameter logic [7:0]             RTC_PORT   = 8'h70,
   parameter int                     RTC_SLOT   = 'h31,
   parameter logic [7:0]             TMR_PORT   = 8'h40,
   parameter int                     TMR_SLOT   = 'h36
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] io_addr,
   input  logic        io_wr,
   input  logic [7:0]  io_wdata,
   output shw_t        req
);

   if (NFIFO < 1 || NFIFO > 8) begin : g_bad_nfifo
      $error("shrb_misc_snoop: NFIFO must be 1..8");
   end
   if (TMR_SLOT[0] != 1'b0) begin : g_bad_tslot
      $error("shrb_misc_snoop: TMR_SLOT must be even");
   end

   logic             wr8, rtc_hit, tmr_hit, tptr_q;
   logic [NFIFO-1:0] fifo_hit;

   assign wr8     = io_wr && (io_addr[15:8] == 8'h00);
   assign rtc_hit = wr8 && (io_addr[7:0] == RTC_PORT);
   assign tmr_hit = wr8 && (io_addr[7:0] == TMR_PORT);

   for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
      assign fifo_hit[f] = io_wr && (io_addr == FIFO_PORT[f]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tptr_q <= 1'b0;
      else if (tmr_hit) tptr_q <= ~tptr_q;
   end

   always_comb begin
      req      = '0;
      req.data = io_wdata;
      if (rtc_hit) begin
         req.vld  = 1'b1;
         req.slot = SLOT_W'(RTC_SLOT);
      end
      if (tmr_hit) begin
         req.vld  = 1'b1;
         req.slot = SLOT_W'(TMR_SLOT + int'(tptr_q));
      end
      for (int f = 0; f < NFIFO; f++) begin
         if (fifo_hit[f]) begin
            req.vld  = 1'b1;
            req.slot = SLOT_W'(FIFO_SLOT0 + f);
            req.data = io_wdata & FIFO_KEEP;
         end
      end
   end

endmodule

// File: rtl/shrb_store.sv
module shrb_store
   import shrb_pkg::*;
#(
   parameter int ENTRIES = NUM_ENT,
   parameter int SEL_W   = IDX_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  shw_t             wr,
   input  logic             sel_wr,
   input  logic [7:0]       sel_data,
   input  logic             rd,
   output logic [SEL_W-1:0] sel_q,
   output logic [7:0]       rdata
);

   if (ENTRIES > (1 << SLOT_W)) begin : g_bad_ent
      $error("shrb_store: ENTRIES exceeds slot field range");
   end
   if (SEL_W != 8) begin : g_bad_sel
      $error("shrb_store: SEL_W must equal the data width");
   end

   logic [7:0] mem [ENTRIES];
   logic [7:0] rd_val;
   logic [7:0] rdata_q;

   always_comb begin
      rd_val = 8'h00;
      for (int e = 0; e < ENTRIES; e++) begin
         if (sel_q == SEL_W'(e)) rd_val = mem[e];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) mem[e] <= 8'h00;
         sel_q   <= '0;
         rdata_q <= 8'h00;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (wr.vld && wr.slot == SLOT_W'(e)) mem[e] <= wr.data;
         end
         if (sel_wr) sel_q   <= sel_data;
         if (rd)     rdata_q <= rd_val;
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/wo_shadow_unit.sv
module wo_shadow_unit
   import shrb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] io_addr,
   input  logic        io_wr,
   input  logic [7:0]  io_wdata,
   input  logic        sh_wr,
   input  logic        sh_rd,
   output logic [7:0]  sh_rdata
);

   localparam int NSRC = 5;

   shw_t             src [NSRC];
   shw_t             wr_req;
   logic             dma1_ptr, dma2_ptr;
   logic [IDX_W-1:0] idx_q;

   shrb_dma_snoop #(
      .NCH(4), .FIRST_CH(0), .REG_BASE(8'h00), .REG_STEP(1),
      .CMD_PORT(8'h08), .MODE_PORT(8'h0B), .MASK_PORT(8'h0F), .CLR_PORT(8'h0C),
      .REG_SLOT0('h00), .CMD_SLOT('h10), .MODE_SLOT0('h11), .MASK_SLOT('h15)
   ) u_dma1 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .req(src[0]), .ptr_o(dma1_ptr)
   );

   shrb_dma_snoop #(
      .NCH(4), .FIRST_CH(1), .REG_BASE(8'hC0), .REG_STEP(2),
      .CMD_PORT(8'hD0), .MODE_PORT(8'hD6), .MASK_PORT(8'hDE), .CLR_PORT(8'hD8),
      .REG_SLOT0('h16), .CMD_SLOT('h22), .MODE_SLOT0('h23), .MASK_SLOT('h26)
   ) u_dma2 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .req(src[1]), .ptr_o(dma2_ptr)
   );

   shrb_pic_snoop #(
      .EVEN_PORT(8'h20), .ICW1_SLOT('h27), .OCW2_SLOT('h2B), .OCW3_SLOT('h38)
   ) u_pic1 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .req(src[2])
   );

   shrb_pic_snoop #(
      .EVEN_PORT(8'hA0), .ICW1_SLOT('h2C), .OCW2_SLOT('h30), .OCW3_SLOT('h39)
   ) u_pic2 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .req(src[3])
   );

   shrb_misc_snoop #(
      .NFIFO(4)
   ) u_misc (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .req(src[4])
   );

   // port ranges are disjoint, so at most one source is valid per cycle
   always_comb begin
      wr_req = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (src[s].vld) wr_req = src[s];
      end
   end

   shrb_store #(
      .ENTRIES(NUM_ENT), .SEL_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr(wr_req),
      .sel_wr(sh_wr), .sel_data(io_wdata), .rd(sh_rd),
      .sel_q(idx_q), .rdata(sh_rdata)
   );

endmodule

// File: rtl/shrb_checker.sv
module shrb_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] io_addr,
   input logic        io_wr,
   input logic [7:0]  io_wdata,
   input logic        sh_wr,
   input logic        sh_rd,
   input logic [7:0]  sh_rdata,
   input logic [7:0]  idx_q,
   input logic        dma1_ptr,
   input logic        dma2_ptr
);

   // R1: output only moves on a shadow read
   p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_rd |=> $stable(sh_rdata));

   // R1: shadow port write captures the selection
   p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sh_wr |=> idx_q == $past(io_wdata));

   // R12: selection kept until rewritten
   p_idx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_wr |=> $stable(idx_q));

   // R12: out-of-range selection reads zero
   p_oor_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_rd && idx_q > 8'h39) |=> sh_rdata == 8'h00);

   // R10: FIFO control shadows keep only bits 0,3,6,7
   p_fifo_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_rd && idx_q >= 8'h32 && idx_q <= 8'h35) |=> (sh_rdata & 8'h36) == 8'h00);

   // R8: OCW3 shadows keep only bits 0,2,5
   p_ocw3_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_rd && (idx_q == 8'h38 || idx_q == 8'h39)) |=> (sh_rdata & 8'hDA) == 8'h00);

   // R4: clear-pointer ports
   p_ptr1_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == 16'h000C) |=> !dma1_ptr);

   p_ptr2_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == 16'h00D8) |=> !dma2_ptr);

   // R3: an address write on the first controller flips its pointer
   p_ptr1_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == 16'h0000) |=> dma1_ptr != $past(dma1_ptr));

endmodule

bind wo_shadow_unit shrb_checker u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
   .io_wdata(io_wdata), .sh_wr(sh_wr), .sh_rd(sh_rd), .sh_rdata(sh_rdata),
   .idx_q(idx_q), .dma1_ptr(dma1_ptr), .dma2_ptr(dma2_ptr)
);

// File: tb/wo_shadow_unit_test.sv
module wo_shadow_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic        sh_wr = 1'b0;
   logic        sh_rd = 1'b0;
   logic [7:0]  sh_rdata;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;  // 100 MHz

   wo_shadow_unit uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .sh_wr(sh_wr), .sh_rd(sh_rd), .sh_rdata(sh_rdata)
   );

   // vector: {op, addr, data/slot, expected, requirement}
   typedef logic [37:0] vec_t;
   localparam logic [1:0] IOW = 2'd0;  // snooped port write
   localparam logic [1:0] CHK = 2'd1;  // select slot, read, compare

   localparam int NV = 60;
   localparam vec_t VEC [NV] = '{
      // R3 byte order, first controller
      {IOW, 16'h0000, 8'h34, 8'h00, 4'd3},
      {IOW, 16'h0000, 8'h12, 8'h00, 4'd3},
      {CHK, 16'h0000, 8'h00, 8'h34, 4'd3},
      {CHK, 16'h0000, 8'h01, 8'h12, 4'd3},
      {IOW, 16'h0003, 8'h55, 8'h00, 4'd3},
      {IOW, 16'h0007, 8'h66, 8'h00, 4'd3},
      {CHK, 16'h0000, 8'h06, 8'h55, 4'd3},
      {CHK, 16'h0000, 8'h0F, 8'h66, 4'd3},
      // R4 clear pointer between halves
      {IOW, 16'h0002, 8'hA1, 8'h00, 4'd4},
      {IOW, 16'h000C, 8'h00, 8'h00, 4'd4},
      {IOW, 16'h0002, 8'hB2, 8'h00, 4'd4},
      {CHK, 16'h0000, 8'h04, 8'hB2, 4'd4},
      {CHK, 16'h0000, 8'h05, 8'h00, 4'd4},
      // R3 second controller, channel 4 port flips pointer only
      {IOW, 16'h00C0, 8'h11, 8'h00, 4'd3},
      {IOW, 16'h00C4, 8'h77, 8'h00, 4'd3},
      {CHK, 16'h0000, 8'h17, 8'h77, 4'd3},
      {CHK, 16'h0000, 8'h16, 8'h00, 4'd3},
      {IOW, 16'h00CE, 8'h88, 8'h00, 4'd4},
      {IOW, 16'h00D8, 8'h00, 8'h00, 4'd4},
      {IOW, 16'h00CE, 8'h99, 8'h00, 4'd4},
      {CHK, 16'h0000, 8'h20, 8'h99, 4'd4},
      // R5 command and mask
      {IOW, 16'h0008, 8'hC3, 8'h00, 4'd5},
      {IOW, 16'h000F, 8'h0E, 8'h00, 4'd5},
      {IOW, 16'h00D0, 8'h5A, 8'h00, 4'd5},
      {IOW, 16'h00DE, 8'h0F, 8'h00, 4'd5},
      {CHK, 16'h0000, 8'h10, 8'hC3, 4'd5},
      {CHK, 16'h0000, 8'h15, 8'h0E, 4'd5},
      {CHK, 16'h0000, 8'h22, 8'h5A, 4'd5},
      {CHK, 16'h0000, 8'h26, 8'h0F, 4'd5},
      // R6 mode sorting
      {IOW, 16'h000B, 8'h4A, 8'h00, 4'd6},
      {IOW, 16'h000B, 8'h57, 8'h00, 4'd6},
      {IOW, 16'h00D6, 8'h41, 8'h00, 4'd6},
      {IOW, 16'h00D6, 8'h44, 8'h00, 4'd6},
      {IOW, 16'h00D6, 8'h4B, 8'h00, 4'd6},
      {CHK, 16'h0000, 8'h13, 8'h4A, 4'd6},
      {CHK, 16'h0000, 8'h14, 8'h57, 4'd6},
      {CHK, 16'h0000, 8'h23, 8'h41, 4'd6},
      {CHK, 16'h0000, 8'h24, 8'h00, 4'd6},
      {CHK, 16'h0000, 8'h25, 8'h4B, 4'd6},
      // R7 full sequence, then a mask write that must not land
      {IOW, 16'h0020, 8'h11, 8'h00, 4'd7},
      {IOW, 16'h0021, 8'h08, 8'h00, 4'd7},
      {IOW, 16'h0021, 8'h04, 8'h00, 4'd7},
      {IOW, 16'h0021, 8'h01, 8'h00, 4'd7},
      {IOW, 16'h0021, 8'hFB, 8'h00, 4'd7},
      {CHK, 16'h0000, 8'h28, 8'h08, 4'd7},
      {CHK, 16'h0000, 8'h29, 8'h04, 4'd7},
      {CHK, 16'h0000, 8'h2A, 8'h01, 4'd7},
      // R7 single mode: ICW3 skipped
      {IOW, 16'h00A0, 8'h13, 8'h00, 4'd7},
      {IOW, 16'h00A1, 8'h70, 8'h00, 4'd7},
      {IOW, 16'h00A1, 8'h03, 8'h00, 4'd7},
      {IOW, 16'h00A1, 8'hFF, 8'h00, 4'd7},
      {CHK, 16'h0000, 8'h2C, 8'h13, 4'd7},
      {CHK, 16'h0000, 8'h2D, 8'h70, 4'd7},
      {CHK, 16'h0000, 8'h2E, 8'h00, 4'd7},
      {CHK, 16'h0000, 8'h2F, 8'h03, 4'd7},
      // R8 OCW2 and masked OCW3
      {IOW, 16'h0020, 8'h20, 8'h00, 4'd8},
      {IOW, 16'h00A0, 8'h6B, 8'h00, 4'd8},
      {CHK, 16'h0000, 8'h2B, 8'h20, 4'd8},
      {CHK, 16'h0000, 8'h39, 8'h21, 4'd8},
      {CHK, 16'h0000, 8'h30, 8'h00, 4'd8}
   };

   function automatic string req_name(input int r);
      case (r)
         1:  return "R1";
         2:  return "R2";
         3:  return "R3";
         4:  return "R4";
         5:  return "R5";
         6:  return "R6";
         7:  return "R7";
         8:  return "R8";
         9:  return "R9";
         10: return "R10";
         11: return "R11";
         12: return "R12";
         13: return "R13";
         default: return "R?";
      endcase
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input int r);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: sh_rdata=%02h expected %02h", req_name(r), act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic select(input logic [7:0] s);
      @(negedge clk);
      io_wdata = s; sh_wr = 1'b1;
      @(negedge clk);
      sh_wr = 1'b0;
   endtask

   task automatic read_chk(input logic [7:0] exp, input int r);
      @(negedge clk);
      sh_rd = 1'b1;
      @(negedge clk);
      sh_rd = 1'b0;
      check(sh_rdata, exp, r);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset state of output and default selection (slot 00h)
      @(negedge clk);
      check(sh_rdata, 8'h00, 2);
      read_chk(8'h00, 2);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v][37:36] == IOW) begin
            io_write(VEC[v][35:20], VEC[v][19:12]);
         end else begin
            select(VEC[v][19:12]);
            read_chk(VEC[v][11:4], int'(VEC[v][3:0]));
         end
      end

      // R9: RTC index and timer 0 byte pair
      io_write(16'h0070, 8'h8D);
      io_write(16'h0040, 8'h9C);
      io_write(16'h0040, 8'h2E);
      select(8'h31); read_chk(8'h8D, 9);
      select(8'h36); read_chk(8'h9C, 9);
      select(8'h37); read_chk(8'h2E, 9);

      // R10: FIFO control bit filtering
      io_write(16'h03FA, 8'hFF);
      io_write(16'h02EA, 8'h87);
      select(8'h32); read_chk(8'hC9, 10);
      select(8'h35); read_chk(8'h81, 10);

      // R11: upper address bits must be zero for 8-bit ports
      io_write(16'h1070, 8'h33);
      io_write(16'h0108, 8'h00);
      io_write(16'h1000, 8'hEE);   // must not flip the pointer (still high)
      io_write(16'h0000, 8'h44);   // lands in the high byte, slot 01h
      select(8'h31); read_chk(8'h8D, 11);
      select(8'h10); read_chk(8'hC3, 11);
      select(8'h01); read_chk(8'h44, 11);
      select(8'h00); read_chk(8'h34, 11);

      // R12: out-of-range selection, and selection held across I/O writes
      select(8'h3A); read_chk(8'h00, 12);
      select(8'hFF); read_chk(8'h00, 12);
      io_write(16'h0070, 8'h5E);
      read_chk(8'h00, 12);

      // R13: snooped write and shadow read in the same cycle
      select(8'h31);
      @(negedge clk);
      io_addr = 16'h0070; io_wdata = 8'h05; io_wr = 1'b1; sh_rd = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; sh_rd = 1'b0;
      check(sh_rdata, 8'h5E, 13);
      read_chk(8'h05, 13);

      // R1: output holds while a write changes the selected slot
      select(8'h36); read_chk(8'h9C, 1);
      io_write(16'h0040, 8'h12);   // timer pointer is low again
      @(negedge clk);
      check(sh_rdata, 8'h9C, 1);
      read_chk(8'h12, 1);

      // R2: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sh_rdata, 8'h00, 2);
      read_chk(8'h00, 2);
      select(8'h36); read_chk(8'h00, 2);
      io_write(16'h0040, 8'hAB);   // timer pointer back to low
      read_chk(8'hAB, 2);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule